// File: doc/BRIEF.md
# Dual-Identity I2C Target with Software Clock Hold

This block is an I2C target that answers on two independently programmed 7-bit device addresses, called slot A and slot B. Each slot has its own address register, receive byte, transmit byte and three event flags: matched, byte received and transmit byte taken. A controller on the serial side can write bytes into a slot or read bytes out of it. A local processor reaches every register through a single-cycle, byte-wide register port and takes one level interrupt.

The serial lines are open-drain. The block samples SCL and SDA through synchronizers, and it pulls either line low by raising the matching output enable. With the clock-hold option turned on, the block keeps SCL low while a received byte is still unread or a transmit byte is still unrefilled. The controller then waits for the processor to act, so no byte is overwritten or sent stale.

Register port map (3-bit address): 0 control, 1 status, 2 flags, 3 interrupt enables, 4 slot A address, 5 slot A data, 6 slot B address, 7 slot B data. A read of a data register returns the receive byte. A write to a data register loads the transmit byte.

Top module: `dual_i2c_target`

## Requirements
- R1: A slot answers only while it is enabled (control bit0 for A, bit1 for B). The bits [7:1] of the first byte after a START must equal that slot's address register (reg 4 for A, reg 6 for B). On a match the block drives ACK on the ninth clock, and in a write transfer it ACKs every data byte. A mismatch or a disabled slot gets no ACK and sets no flag.
- R2: A match sets that slot's matched flag (flags bit0 for A, bit3 for B). Writing 0 to that bit of reg 2 clears the flag. Writing 1 leaves it set. The other bits of reg 2 cannot be written.
- R3: Each byte written by the controller lands in the matched slot's receive byte (read at reg 5 or reg 7) and sets its received flag (bit1 for A, bit4 for B). A processor read of that data register clears the flag.
- R4: In a read transfer the transmit byte of the slot is copied to the shifter at the address ACK and again after every byte the controller ACKs. Each copy sets the slot's taken flag (bit2 for A, bit5 for B). A processor write to the data register clears the flag and supplies the next byte.
- R5: A NACK from the controller after a read byte ends the transfer. SDA is released and the block goes idle until the next START.
- R6: With control bit2 set, SCL is held low, once it has fallen, while any received or taken flag of either slot is pending. It is released once none is pending. With bit2 clear, SCL is never driven.
- R7: Status reg 1 reads as follows. Bit0 is 1 while a slot is addressed (from the match until STOP, NACK or mismatch). Bit1 is the direction bit of the last match (1 = read). Bit2 is 1 when the controller ACKed the last byte sent. Bit3 is 1 when slot B made the last match.
- R8: `irq` is high exactly while some flag is set whose enable bit in reg 3 is set (the same bit positions as reg 2).
- R9: After reset the control, status, flags and enable registers read 0, both line enables are low and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Sensed level of the serial clock line |
| sda_i | input | 1 | Sensed level of the serial data line |
| scl_oe | output | 1 | Pulls the clock line low when high |
| sda_oe | output | 1 | Pulls the data line low when high |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register index |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the cycle of the access |
| irq | output | 1 | Level interrupt |

## Verification
The bench goes after clock hold at byte boundaries. It stalls the processor after a received byte and checks that the clock line stays low, so a design that ignored the hold would let the controller overrun the unread byte. Read transfers check the exact byte order across refills: a design that copied the transmit byte at the wrong ACK would send a stale or repeated byte. The bench also sends an address that matches neither slot and an address for a disabled slot, which a careless comparator would ACK. It writes all-ones to the flag register, which a design that treated any write as a clear would wrongly honour.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_RX, ST_RACK, ST_TX, ST_TACK
   } eng_state_t;

   localparam logic [2:0] REG_CTRL  = 3'd0;
   localparam logic [2:0] REG_STAT  = 3'd1;
   localparam logic [2:0] REG_FLAGS = 3'd2;
   localparam logic [2:0] REG_IEN   = 3'd3;
   localparam int         REG_ADDR0 = 4;
   localparam int         REG_DATA0 = 5;
   localparam int         FLAG_W    = 3;
   localparam int         NSLOT     = 2;
endpackage

// File: rtl/i2ct_sync.sv
module i2ct_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_p,
   output logic stop_p
);
   logic [STAGES-1:0] scl_q, sda_q;
   logic              scl_d, sda_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= '1;
         sda_q <= '1;
         scl_d <= 1'b1;
         sda_d <= 1'b1;
      end else begin
         scl_q <= {scl_q[STAGES-2:0], scl_i};
         sda_q <= {sda_q[STAGES-2:0], sda_i};
         scl_d <= scl_q[STAGES-1];
         sda_d <= sda_q[STAGES-1];
      end
   end

   assign scl_s    = scl_q[STAGES-1];
   assign sda_s    = sda_q[STAGES-1];
   assign scl_rise = scl_s & ~scl_d;
   assign scl_fall = ~scl_s & scl_d;
   assign start_p  = scl_s & scl_d & sda_d & ~sda_s;
   assign stop_p   = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2ct_slot.sv
module i2ct_slot #(
   parameter logic [6:0] ADDR_RST = 7'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       addr_we,
   input  logic       data_we,
   input  logic       data_re,
   input  logic       mflag_clr,
   input  logic [7:0] wdata,
   input  logic       match_set,
   input  logic       rx_push,
   input  logic [7:0] rx_byte,
   input  logic       tx_load,
   output logic [6:0] addr,
   output logic [7:0] rx_buf,
   output logic [7:0] tx_buf,
   output logic       match_f,
   output logic       rx_f,
   output logic       tx_f
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr    <= ADDR_RST;
         rx_buf  <= '0;
         tx_buf  <= '0;
         match_f <= 1'b0;
         rx_f    <= 1'b0;
         tx_f    <= 1'b0;
      end else begin
         if (addr_we) addr <= wdata[6:0];
         if (data_we) tx_buf <= wdata;
         if (rx_push) rx_buf <= rx_byte;
         if (match_set)      match_f <= 1'b1;
         else if (mflag_clr) match_f <= 1'b0;
         if (rx_push)        rx_f <= 1'b1;
         else if (data_re)   rx_f <= 1'b0;
         if (tx_load)        tx_f <= 1'b1;
         else if (data_we)   tx_f <= 1'b0;
      end
   end

   // R3
   rx_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_f) |-> $past(rx_push));
   // R3
   rx_read_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_re && !rx_push) |=> !rx_f);
   // R4
   tx_write_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !tx_load) |=> !tx_f);
   // R2
   match_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(match_f) |-> $past(mflag_clr));
endmodule

// File: rtl/i2ct_engine.sv
module i2ct_engine
   import i2ct_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sda_s,
   input  logic                  scl_rise,
   input  logic                  scl_fall,
   input  logic                  start_p,
   input  logic                  stop_p,
   input  logic [NSLOT-1:0]      en,
   input  logic [NSLOT-1:0][6:0] addr,
   input  logic [NSLOT-1:0][7:0] tx_buf,
   output logic                  sda_oe,
   output logic [NSLOT-1:0]      match_set,
   output logic [NSLOT-1:0]      rx_push,
   output logic [NSLOT-1:0]      tx_load,
   output logic [7:0]            rx_byte,
   output logic                  active,
   output logic                  dir,
   output logic                  ack_in,
   output logic                  last_b
);
   eng_state_t state;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic       sel;
   logic [NSLOT-1:0] hit;

   for (genvar k = 0; k < NSLOT; k++) begin : g_hit
      assign hit[k] = en[k] && (sh[7:1] == addr[k]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         sh        <= '0;
         sel       <= 1'b0;
         sda_oe    <= 1'b0;
         dir       <= 1'b0;
         ack_in    <= 1'b0;
         last_b    <= 1'b0;
         match_set <= '0;
         rx_push   <= '0;
         tx_load   <= '0;
      end else begin
         match_set <= '0;
         rx_push   <= '0;
         tx_load   <= '0;
         if (stop_p) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_p) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_ADDR: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     if (|hit) begin
                        sel              <= ~hit[0];
                        last_b           <= ~hit[0];
                        match_set[~hit[0]] <= 1'b1;
                        dir              <= sh[0];
                        sda_oe           <= 1'b1;
                        state            <= ST_AACK;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (dir) begin
                        sh           <= tx_buf[sel];
                        sda_oe       <= ~tx_buf[sel][7];
                        tx_load[sel] <= 1'b1;
                        state        <= ST_TX;
                     end else begin
                        sda_oe <= 1'b0;
                        state  <= ST_RX;
                     end
                  end
               end
               ST_RX: begin
                  if (scl_rise) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall && cnt == 4'd8) begin
                     rx_push[sel] <= 1'b1;
                     sda_oe       <= 1'b1;
                     state        <= ST_RACK;
                  end
               end
               ST_RACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_RX;
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 4'd1;
                  end else if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                     end
                  end
               end
               ST_TACK: begin
                  if (scl_rise) begin
                     ack_in <= ~sda_s;
                  end else if (scl_fall) begin
                     if (ack_in) begin
                        cnt          <= '0;
                        sh           <= tx_buf[sel];
                        sda_oe       <= ~tx_buf[sel][7];
                        tx_load[sel] <= 1'b1;
                        state        <= ST_TX;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rx_byte = sh;
   assign active  = (state != ST_IDLE) && (state != ST_ADDR);

   // R1
   match_acks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((|match_set) && !start_p && !stop_p) |-> sda_oe);
   // R5
   nack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_TACK && scl_fall && !ack_in && !start_p && !stop_p)
      |=> (state == ST_IDLE && !sda_oe));
endmodule

// File: rtl/dual_i2c_target.sv
module dual_i2c_target
   import i2ct_pkg::*;
#(
   parameter int         SYNC_STAGES = 2,
   parameter bit         STRETCH_EN  = 1'b1,
   parameter logic [6:0] ADDR_A_RST  = 7'h00,
   parameter logic [6:0] ADDR_B_RST  = 7'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       scl_oe,
   output logic       sda_oe,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   output logic       irq
);
   localparam int FLAGS_N = NSLOT * FLAG_W;

   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("SYNC_STAGES must lie in 2..4");
   end

   logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
   logic [2:0] ctrl;
   logic [FLAGS_N-1:0] ien, flags;
   logic wr_en, rd_en;
   logic [NSLOT-1:0] addr_we, data_we, data_re, mflag_clr;
   logic [NSLOT-1:0] match_set, rx_push, tx_load, m_f, rx_f, tx_f;
   logic [NSLOT-1:0][6:0] s_addr;
   logic [NSLOT-1:0][7:0] s_rx, s_tx;
   logic [7:0] rx_byte;
   logic active, dir, ack_in, last_b;

   assign wr_en = bus_sel & bus_wr;
   assign rd_en = bus_sel & ~bus_wr;

   i2ct_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_p(start_p), .stop_p(stop_p));

   for (genvar k = 0; k < NSLOT; k++) begin : g_slot
      assign addr_we[k]   = wr_en && (bus_addr == 3'(REG_ADDR0 + 2*k));
      assign data_we[k]   = wr_en && (bus_addr == 3'(REG_DATA0 + 2*k));
      assign data_re[k]   = rd_en && (bus_addr == 3'(REG_DATA0 + 2*k));
      assign mflag_clr[k] = wr_en && (bus_addr == REG_FLAGS) && !bus_wdata[k*FLAG_W];
      assign flags[k*FLAG_W +: FLAG_W] = {tx_f[k], rx_f[k], m_f[k]};

      i2ct_slot #(.ADDR_RST(k == 0 ? ADDR_A_RST : ADDR_B_RST)) u_slot (
         .clk(clk), .rst_n(rst_n), .addr_we(addr_we[k]), .data_we(data_we[k]),
         .data_re(data_re[k]), .mflag_clr(mflag_clr[k]), .wdata(bus_wdata),
         .match_set(match_set[k]), .rx_push(rx_push[k]), .rx_byte(rx_byte),
         .tx_load(tx_load[k]), .addr(s_addr[k]), .rx_buf(s_rx[k]), .tx_buf(s_tx[k]),
         .match_f(m_f[k]), .rx_f(rx_f[k]), .tx_f(tx_f[k]));
   end

   i2ct_engine u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_p(start_p), .stop_p(stop_p), .en(ctrl[1:0]),
      .addr(s_addr), .tx_buf(s_tx), .sda_oe(sda_oe), .match_set(match_set),
      .rx_push(rx_push), .tx_load(tx_load), .rx_byte(rx_byte), .active(active),
      .dir(dir), .ack_in(ack_in), .last_b(last_b));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
         ien  <= '0;
      end else if (wr_en) begin
         if (bus_addr == REG_CTRL) ctrl <= bus_wdata[2:0];
         if (bus_addr == REG_IEN)  ien  <= bus_wdata[FLAGS_N-1:0];
      end
   end

   if (STRETCH_EN) begin : g_hold
      logic hold;
      logic pending;
      assign pending = |{rx_f, tx_f};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                 hold <= 1'b0;
         else if (!ctrl[2] || !pending) hold <= 1'b0;
         else if (!scl_s)            hold <= 1'b1;
      end
      assign scl_oe = hold;
   end else begin : g_nohold
      assign scl_oe = 1'b0;
   end

   always_comb begin
      case (bus_addr)
         REG_CTRL:  bus_rdata = {5'b0, ctrl};
         REG_STAT:  bus_rdata = {4'b0, last_b, ack_in, dir, active};
         REG_FLAGS: bus_rdata = 8'(flags);
         REG_IEN:   bus_rdata = 8'(ien);
         3'd4:      bus_rdata = {1'b0, s_addr[0]};
         3'd5:      bus_rdata = s_rx[0];
         3'd6:      bus_rdata = {1'b0, s_addr[1]};
         default:   bus_rdata = s_rx[1];
      endcase
   end

   assign irq = |(flags & ien);

   // R6
   hold_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[2] |=> !scl_oe);
endmodule

// File: tb/dual_i2c_target_test.sv
`timescale 1ns/1ps
module dual_i2c_target_test;
   localparam int HP = 20;
   localparam logic [6:0] AD_A = 7'h2A, AD_B = 7'h51, AD_X = 7'h33;

   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl_low = 1'b0, m_sda_low = 1'b0;
   logic bsel = 1'b0, bwr = 1'b0;
   logic [2:0] badr = '0;
   logic [7:0] bwd = '0;
   logic [7:0] brd;
   logic scl_oe, sda_oe, irq;
   wire scl_bus = ~(m_scl_low | scl_oe);
   wire sda_bus = ~(m_sda_low | sda_oe);

   int nchk = 0, nerr = 0;
   logic mdone = 1'b0;
   logic [8:0] rxq[$];
   logic [7:0] txq_a[$], rdq[$];
   logic [7:0] wbuf[4];

   always #4 clk = ~clk;

   dual_i2c_target uut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .bus_sel(bsel), .bus_wr(bwr),
      .bus_addr(badr), .bus_wdata(bwd), .bus_rdata(brd), .irq(irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cpu_wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bsel = 1'b1; bwr = 1'b1; badr = a; bwd = d;
      @(negedge clk); bsel = 1'b0; bwr = 1'b0;
   endtask

   task automatic cpu_rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bsel = 1'b1; bwr = 1'b0; badr = a;
      #1 d = brd;
      @(negedge clk); bsel = 1'b0;
   endtask

   task automatic pulse(output logic s);
      repeat (HP) @(negedge clk);
      m_scl_low = 1'b0;
      while (!scl_bus) @(negedge clk);
      repeat (HP) @(negedge clk);
      s = sda_bus;
      m_scl_low = 1'b1;
   endtask

   task automatic i2c_start();
      m_sda_low = 1'b1; repeat (HP) @(negedge clk);
      m_scl_low = 1'b1; repeat (HP) @(negedge clk);
   endtask

   task automatic i2c_stop();
      m_sda_low = 1'b1; repeat (HP) @(negedge clk);
      m_scl_low = 1'b0;
      while (!scl_bus) @(negedge clk);
      repeat (HP) @(negedge clk);
      m_sda_low = 1'b0; repeat (HP) @(negedge clk);
   endtask

   task automatic wbyte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i];
         pulse(s);
      end
      m_sda_low = 1'b0;
      pulse(s);
      ack = ~s;
   endtask

   task automatic rbyte(input logic ack, output logic [7:0] b);
      logic s;
      m_sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         pulse(s);
         b[i] = s;
      end
      m_sda_low = ack;
      pulse(s);
      m_sda_low = 1'b0;
   endtask

   // scoreboard monitor: services flags, pops expected receive bytes, refills transmit
   task automatic service();
      logic [7:0] f, d;
      logic [8:0] e;
      while (!mdone) begin
         cpu_rd(3'd2, f);
         if (f[1]) begin
            cpu_rd(3'd5, d);
            e = (rxq.size() != 0) ? rxq.pop_front() : 9'h1FF;
            chk("R3 rx byte slot A", {23'b0, 1'b0, d}, {23'b0, e});
         end
         if (f[4]) begin
            cpu_rd(3'd7, d);
            e = (rxq.size() != 0) ? rxq.pop_front() : 9'h1FF;
            chk("R3 rx byte slot B", {23'b0, 1'b1, d}, {23'b0, e});
         end
         if (f[2]) cpu_wr(3'd5, (txq_a.size() != 0) ? txq_a.pop_front() : 8'h00);
         if (f[5]) cpu_wr(3'd7, 8'h00);
      end
   endtask

   // driver: pushes expected bytes, then runs the transfer
   task automatic do_write(input logic [6:0] ad, input logic slot, input int n,
                           input logic exp_ack, input logic svc);
      logic ack;
      mdone = 1'b0;
      if (svc && exp_ack) for (int i = 0; i < n; i++) rxq.push_back({slot, wbuf[i]});
      fork
         begin
            i2c_start();
            wbyte({ad, 1'b0}, ack);
            chk("R1 address ack", {31'b0, ack}, {31'b0, exp_ack});
            if (exp_ack) for (int i = 0; i < n; i++) begin
               wbyte(wbuf[i], ack);
               chk("R1 data ack", {31'b0, ack}, 32'd1);
            end
            i2c_stop();
            mdone = 1'b1;
         end
         begin
            if (svc) service();
         end
      join
      chk("R3 all bytes seen", rxq.size(), 0);
   endtask

   task automatic do_read(input logic [6:0] ad, input int n);
      logic ack;
      logic [7:0] b;
      mdone = 1'b0;
      fork
         begin
            i2c_start();
            wbyte({ad, 1'b1}, ack);
            chk("R1 read address ack", {31'b0, ack}, 32'd1);
            for (int i = 0; i < n; i++) begin
               rbyte(i != n - 1, b);
               chk("R4 read byte order", {24'b0, b}, {24'b0, rdq.pop_front()});
            end
            repeat (8) @(negedge clk);
            chk("R5 sda released after NACK", {31'b0, sda_oe}, 32'd0);
            i2c_stop();
            mdone = 1'b1;
         end
         service();
      join
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end

   initial begin : main
      logic [7:0] d;
      logic held;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R9 reset state
      for (int r = 0; r < 4; r++) begin
         cpu_rd(3'(r), d);
         chk("R9 reset register", {24'b0, d}, 32'd0);
      end
      chk("R9 line enables", {30'b0, scl_oe, sda_oe}, 32'd0);
      chk("R9 irq low", {31'b0, irq}, 32'd0);

      cpu_wr(3'd4, {1'b0, AD_A});
      cpu_wr(3'd6, {1'b0, AD_B});
      cpu_wr(3'd0, 8'h07);

      // R1 R3 write to slot A with hold serviced
      wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
      do_write(AD_A, 1'b0, 3, 1'b1, 1'b1);
      cpu_rd(3'd2, d); chk("R2 match A flag", {24'b0, d}, 32'h01);
      cpu_rd(3'd1, d); chk("R7 status after A write", {24'b0, d}, 32'h00);

      // write to slot B
      wbuf[0] = 8'hA5; wbuf[1] = 8'h5A;
      do_write(AD_B, 1'b1, 2, 1'b1, 1'b1);
      cpu_rd(3'd2, d); chk("R2 match B flag", {24'b0, d}, 32'h09);
      cpu_rd(3'd1, d); chk("R7 last slot B", {24'b0, d}, 32'h08);

      // R2 writing ones has no effect, zeros clear
      cpu_wr(3'd2, 8'hFF);
      cpu_rd(3'd2, d); chk("R2 ones keep flags", {24'b0, d}, 32'h09);
      cpu_wr(3'd2, 8'h00);
      cpu_rd(3'd2, d); chk("R2 zeros clear", {24'b0, d}, 32'h00);

      // R1 mismatch and disabled slot
      wbuf[0] = 8'h77;
      do_write(AD_X, 1'b0, 1, 1'b0, 1'b0);
      cpu_rd(3'd2, d); chk("R1 mismatch no flags", {24'b0, d}, 32'h00);
      cpu_wr(3'd0, 8'h05);
      do_write(AD_B, 1'b1, 1, 1'b0, 1'b0);
      cpu_rd(3'd2, d); chk("R1 disabled slot no flags", {24'b0, d}, 32'h00);
      cpu_wr(3'd0, 8'h07);

      // R4 R5 read from slot A with refills
      cpu_wr(3'd5, 8'hC3);
      rdq.push_back(8'hC3); rdq.push_back(8'h7E); rdq.push_back(8'h81);
      txq_a.push_back(8'h7E); txq_a.push_back(8'h81);
      do_read(AD_A, 3);
      cpu_rd(3'd1, d); chk("R7 status after read NACK", {24'b0, d}, 32'h02);
      cpu_rd(3'd2, d); chk("R4 taken flag cleared by refill", {24'b0, d}, 32'h01);
      cpu_wr(3'd2, 8'h00);

      // R6 hold observed while received byte unread
      mdone = 1'b0;
      fork
         begin
            wbuf[0] = 8'h99;
            do_write(AD_A, 1'b0, 1, 1'b1, 1'b0);
         end
         begin
            repeat (1500) @(negedge clk);
            chk("R6 SCL held while pending", {31'b0, scl_oe}, 32'd1);
            cpu_rd(3'd1, d); chk("R7 active write in progress", {24'b0, d}, 32'h01);
            chk("R8 irq masked", {31'b0, irq}, 32'd0);
            cpu_wr(3'd3, 8'h02);
            @(negedge clk);
            chk("R8 irq on enabled rx flag", {31'b0, irq}, 32'd1);
            cpu_rd(3'd5, d); chk("R3 held byte", {24'b0, d}, 32'h99);
            repeat (4) @(negedge clk);
            chk("R6 SCL released after read", {31'b0, scl_oe}, 32'd0);
         end
      join
      cpu_rd(3'd2, d); chk("R3 rx flag cleared by read", {24'b0, d[1]}, 32'd0);
      cpu_wr(3'd3, 8'h00);

      // R6 no hold with control bit2 clear
      cpu_wr(3'd0, 8'h03);
      held = 1'b0;
      mdone = 1'b0;
      fork
         begin
            wbuf[0] = 8'h42;
            do_write(AD_A, 1'b0, 1, 1'b1, 1'b0);
         end
         begin
            while (!mdone) begin
               @(negedge clk);
               if (scl_oe) held = 1'b1;
            end
         end
      join
      chk("R6 never held when disabled", {31'b0, held}, 32'd0);
      cpu_rd(3'd2, d); chk("R3 rx flag set", {31'b0, d[1]}, 32'd1);
      cpu_rd(3'd5, d); chk("R3 rx byte no hold", {24'b0, d}, 32'h42);
      cpu_rd(3'd2, d); chk("R3 rx flag clear after read", {31'b0, d[1]}, 32'd0);

      // R8 match interrupt
      cpu_wr(3'd3, 8'h01);
      @(negedge clk);
      chk("R8 irq on match flag", {31'b0, irq}, 32'd1);
      cpu_wr(3'd2, 8'h00);
      @(negedge clk);
      chk("R8 irq drops after clear", {31'b0, irq}, 32'd0);

      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
   end
endmodule